// File: doc/BRIEF.md
# Video Identification Line Encoder

This block places a 20-bit identification code on two lines of the NTSC vertical blanking interval. Software writes a 14-bit payload (an aspect-ratio flag, a display-format flag, further WORD0 bits and two 4-bit words) into two shadow registers. A rising edge of `vsync` copies both shadows into the active set. The block appends a 6-bit CRC to the active payload. On an enabled line whose number is 20 or 283, it emits the 20 bits as a binary level stream.

The stream is timed from the line-start strobe on a 27 MHz clock. The window opens 302 cycles after the strobe (about 11.2 µs). Each bit lasts 2.235 µs, which is 60.345 clocks. A fractional accumulator spreads the odd cycles across the bits so that bit edges never drift by more than one clock. `vid_lvl` high requests the 70 IRE level and low requests blanking. Downstream logic turns this level code into the analog value.

The controller has three states. In `ST_IDLE` it waits for a qualifying strobe (transition *arm*). In `ST_WAIT` it counts the start delay (transition *launch*). In `ST_SEND` it shifts out 20 bits and then returns to idle (transition *finish*).

Top module: `vid_id_line_enc`

## Requirements
- R1: After reset, `vid_win` and `vid_lvl` are low and both active payload registers hold zero.
- R2: A window is opened only by a `line_start` pulse sampled while `vid_en` is 1 and `line_num` is 20 or 283. On any other line, or with `vid_en` at 0, both outputs stay low.
- R3: `vid_win` rises exactly 302 cycles after the clock edge that samples the qualifying `line_start`.
- R4: The window lasts 1206 cycles and holds 20 bits. Bit k starts floor(k*60.345) cycles after the window opens, so every bit boundary is within one clock of the ideal 2.235 µs grid.
- R5: The bits go out in this order. First come active WORD0 bits 0..5; bits 0..2 are field A, and bit 0 is the aspect-ratio flag, where 1 means 16:9. Next come active WORD12 bits 0..3 (WORD1), then bits 4..7 (WORD2), and last the CRC with its MSB first.
- R6: The CRC uses the generator x^6+x+1 with the register preset to 111111. It runs over the 14 payload bits in transmission order.
- R7: A write changes only a shadow register. The active copy takes the shadow value on the clock edge that samples a rising `vsync`, and a write made on that same edge takes effect at the next rising edge.
- R8: `vid_lvl` is low whenever `vid_win` is low.
- R9: A `line_start` that arrives while a code is being sent is ignored and does not disturb the current window.
- R10: `wr_sel` = 0 writes `wr_data[5:0]` into the WORD0 shadow, and `wr_sel` = 1 writes all of `wr_data` into the WORD12 shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_num | input | 10 | Current line number |
| line_start | input | 1 | One-cycle line reference strobe |
| vsync | input | 1 | Vertical sync; its rising edge loads the active registers |
| vid_en | input | 1 | Enables insertion of the code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects WORD0, 1 selects WORD12 |
| wr_data | input | 8 | Write data |
| vid_win | output | 1 | High during the 20-bit window |
| vid_lvl | output | 1 | 1 = 70 IRE, 0 = blanking |

## Verification
The encoder is exercised with five payloads: the reset value of zero, which is dominated by the CRC preset; all ones; two mixed patterns; and data written but not yet loaded. Together they distinguish a wrong bit order, a wrong CRC and a missing double buffer. Lines 20 and 283 are each run enabled. Line 21 enabled and line 20 disabled must stay silent, which shows the line and enable qualification. A second strobe in mid-window shows that a busy encoder ignores it. Every cycle is compared with a behavioural model that places bit edges at floor(k*60.345), so an accumulator fault or an integer-only bit period shows up as a shifted edge.

// File: rtl/vid_id_pkg.sv
package vid_id_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SEND
    } vid_state_t;

    // CRC over payload, payload[13] sent first; generator x^6 + x + 1, preset ones
    function automatic logic [5:0] crc6_calc(input logic [13:0] payload);
        logic [5:0] c;
        logic       fb;
        c = 6'h3F;
        for (int i = 13; i >= 0; i--) begin
            fb = payload[i] ^ c[5];
            c  = {c[4:0], fb} ^ {4'b0000, fb, 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/vid_id_regs.sv
module vid_id_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       vsync,
    output logic [5:0] act_w0,
    output logic [7:0] act_w12
);
    logic [5:0] sh_w0;
    logic [7:0] sh_w12;
    logic       vs_q;
    logic       vs_rise;

    assign vs_rise = vsync & ~vs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_w0   <= '0;
            sh_w12  <= '0;
            act_w0  <= '0;
            act_w12 <= '0;
            vs_q    <= 1'b0;
        end else begin
            vs_q <= vsync;
            if (vs_rise) begin
                act_w0  <= sh_w0;
                act_w12 <= sh_w12;
            end
            if (wr_en) begin
                if (wr_sel) sh_w12 <= wr_data;
                else        sh_w0  <= wr_data[5:0];
            end
        end
    end
endmodule

// File: rtl/vid_id_frame.sv
module vid_id_frame
    import vid_id_pkg::*;
(
    input  logic [5:0]  w0,
    input  logic [7:0]  w12,
    output logic [19:0] frame
);
    logic [13:0] payload;

    // payload[13] is the first bit on the line
    for (genvar i = 0; i < 6; i++) begin : g_w0
        assign payload[13-i] = w0[i];
    end
    for (genvar j = 0; j < 8; j++) begin : g_w12
        assign payload[7-j] = w12[j];
    end

    assign frame = {payload, crc6_calc(payload)};
endmodule

// File: rtl/vid_id_bit_timer.sv
module vid_id_bit_timer #(
    parameter int BIT_INT  = 60,
    parameter int FRAC_NUM = 69,
    parameter int FRAC_DEN = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic bit_end
);
    localparam int CW = $clog2(BIT_INT + 1);
    localparam int AW = $clog2(FRAC_DEN + FRAC_NUM);

    logic [CW-1:0] ccnt;
    logic [AW-1:0] acc;
    logic [AW-1:0] sum;
    logic          carry;
    logic [CW-1:0] last_c;

    always_comb begin
        sum     = acc + AW'(FRAC_NUM);
        carry   = (sum >= AW'(FRAC_DEN));
        last_c  = carry ? CW'(BIT_INT) : CW'(BIT_INT - 1);
        bit_end = run && (ccnt == last_c);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ccnt <= '0;
            acc  <= '0;
        end else if (run) begin
            if (bit_end) begin
                ccnt <= '0;
                acc  <= carry ? (sum - AW'(FRAC_DEN)) : sum;
            end else begin
                ccnt <= ccnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vid_id_line_enc.sv
module vid_id_line_enc
    import vid_id_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int LINE_A    = 20,
    parameter int LINE_B    = 283,
    parameter int START_DLY = 302,
    parameter int BIT_INT   = 60,
    parameter int FRAC_NUM  = 69,
    parameter int FRAC_DEN  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_num,
    input  logic              line_start,
    input  logic              vsync,
    input  logic              vid_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    output logic              vid_win,
    output logic              vid_lvl
);
    localparam int NBITS = 20;
    localparam int IW    = $clog2(NBITS);
    localparam int DW    = $clog2(START_DLY);

    vid_state_t    state, nxt;
    logic [5:0]    act_w0;
    logic [7:0]    act_w12;
    logic [19:0]   frame;
    logic [19:0]   shreg;
    logic [DW-1:0] dly_cnt;
    logic [IW-1:0] bit_idx;
    logic          bit_end;
    logic          hit;

    vid_id_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .vsync(vsync), .act_w0(act_w0), .act_w12(act_w12)
    );

    vid_id_frame u_frame (.w0(act_w0), .w12(act_w12), .frame(frame));

    vid_id_bit_timer #(.BIT_INT(BIT_INT), .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_WAIT),
        .run(state == ST_SEND), .bit_end(bit_end)
    );

    assign hit = line_start && vid_en &&
                 (line_num == LINE_W'(LINE_A) || line_num == LINE_W'(LINE_B));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (hit) nxt = ST_WAIT;
            ST_WAIT: if (dly_cnt == DW'(START_DLY - 1)) nxt = ST_SEND;
            ST_SEND: if (bit_end && bit_idx == IW'(NBITS - 1)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_cnt <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (hit) begin
                    dly_cnt <= '0;
                    shreg   <= frame;
                end
                ST_WAIT: begin
                    dly_cnt <= dly_cnt + 1'b1;
                    bit_idx <= '0;
                end
                ST_SEND: if (bit_end) begin
                    shreg   <= {shreg[18:0], 1'b0};
                    bit_idx <= bit_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        vid_win = (state == ST_SEND);
        vid_lvl = vid_win && shreg[19];
    end
endmodule

// File: rtl/vid_id_line_enc_chk.sv
module vid_id_line_enc_chk #(
    parameter int LINE_W    = 10,
    parameter int LINE_A    = 20,
    parameter int LINE_B    = 283,
    parameter int START_DLY = 302,
    parameter int BIT_INT   = 60,
    parameter int FRAC_NUM  = 69,
    parameter int FRAC_DEN  = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINE_W-1:0] line_num,
    input logic              line_start,
    input logic              vid_en,
    input logic              vid_win,
    input logic              vid_lvl,
    input logic              bit_end
);
    localparam int TOTAL = 20 * BIT_INT + (20 * FRAC_NUM) / FRAC_DEN;

    logic [15:0] since;
    logic [15:0] win_len;
    logic        tag_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since   <= 16'hFFFF;
            win_len <= '0;
            tag_ok  <= 1'b0;
        end else begin
            if (line_start) begin
                since  <= '0;
                tag_ok <= vid_en && (line_num == LINE_W'(LINE_A) || line_num == LINE_W'(LINE_B));
            end else if (since != 16'hFFFF) begin
                since <= since + 1'b1;
            end
            win_len <= vid_win ? win_len + 1'b1 : '0;
        end
    end

    // R2: a window only follows a qualifying strobe
    p_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_win) |-> tag_ok);

    // R3: window opens at the fixed delay
    p_start_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_win) |-> since == 16'(START_DLY));

    // R4: full window length
    p_win_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vid_win) |-> win_len == 16'(TOTAL));

    // R4: level changes only at a bit boundary
    p_bit_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_win && $past(vid_win) && !$past(bit_end)) |-> $stable(vid_lvl));
endmodule

bind vid_id_line_enc vid_id_line_enc_chk #(
    .LINE_W(LINE_W), .LINE_A(LINE_A), .LINE_B(LINE_B), .START_DLY(START_DLY),
    .BIT_INT(BIT_INT), .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .line_start(line_start),
    .vid_en(vid_en), .vid_win(vid_win), .vid_lvl(vid_lvl), .bit_end(bit_end)
);

// File: tb/sim_vid_id_line_enc.sv
module sim_vid_id_line_enc;
    localparam int T_CLK   = 38;
    localparam int DLY     = 302;
    localparam int WIN     = 1206;
    localparam int WDOG    = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] line_num = '0;
    logic       line_start = 1'b0;
    logic       vsync = 1'b0;
    logic       vid_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       vid_win;
    logic       vid_lvl;

    always #(T_CLK/2) clk = ~clk;

    vid_id_line_enc u0 (
        .clk(clk), .rst_n(rst_n), .line_num(line_num), .line_start(line_start),
        .vsync(vsync), .vid_en(vid_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .vid_win(vid_win), .vid_lvl(vid_lvl)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // ---------------- reference model ----------------
    int   sh0 = 0, sh12 = 0, ac0 = 0, ac12 = 0;
    bit   vs_prev = 0;
    bit   m_on = 0;
    int   m_t = 0;
    bit   m_bits [20];
    int   win_cycles = 0;

    function automatic int ref_crc(input bit p [14]);
        int c = 63;
        for (int i = 0; i < 14; i++) begin
            int fb = p[i] ^ ((c >> 5) & 1);
            c = ((c << 1) & 63) | fb;
            if (fb != 0) c = c ^ 2;
        end
        return c;
    endfunction

    task automatic build(input int w0, input int w12);
        bit p [14];
        int c;
        for (int i = 0; i < 6; i++) p[i] = bit'((w0 >> i) & 1);      // R5 WORD0 bits 0..5
        for (int j = 0; j < 8; j++) p[6+j] = bit'((w12 >> j) & 1);   // R5 WORD1 then WORD2
        c = ref_crc(p);                                               // R6
        for (int i = 0; i < 14; i++) m_bits[i] = p[i];
        for (int j = 0; j < 6; j++) m_bits[14+j] = bit'((c >> (5-j)) & 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            sh0 = 0; sh12 = 0; ac0 = 0; ac12 = 0; vs_prev = 0; m_on = 0; m_t = 0;
        end else begin
            if (m_on) begin
                m_t++;
                if (m_t == DLY + WIN) m_on = 0;
            end else if (line_start && vid_en && (line_num == 20 || line_num == 283)) begin
                m_on = 1; m_t = 0;
                build(ac0, ac12);
            end
            if (vsync && !vs_prev) begin ac0 = sh0; ac12 = sh12; end   // R7
            vs_prev = vsync;
            if (wr_en) begin                                            // R10
                if (wr_sel) sh12 = int'(wr_data);
                else        sh0  = int'(wr_data) & 63;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ew, el;
            int off, k;
            off = m_t - DLY;
            ew = m_on && off >= 0 && off < WIN;
            el = 1'b0;
            if (ew) begin
                k = 0;
                for (int b = 0; b < 20; b++) if ((b * 60345) / 1000 <= off) k = b;  // R4
                el = m_bits[k];
            end
            if (vid_win) win_cycles++;
            checks++;
            if (vid_win !== ew) begin
                fails++;
                $display("FAIL %s vid_win cyc=%0d actual=%b expected=%b", tag, cyc, vid_win, ew);
            end
            checks++;
            if (vid_lvl !== el) begin   // R8 covered: el is 0 outside window
                fails++;
                $display("FAIL %s vid_lvl cyc=%0d actual=%b expected=%b", tag, cyc, vid_lvl, el);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input bit sel, input int d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = 8'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic vs_pulse();
        @(negedge clk); vsync = 1'b1;
        repeat (3) @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic line(input int ln, input bit en, input int expect_win, input bit retrig);
        win_cycles = 0;
        @(negedge clk); line_num = 10'(ln); vid_en = en; line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        if (retrig) begin
            repeat (600) @(negedge clk);
            line_num = 10'd20; vid_en = 1'b1; line_start = 1'b1;   // R9 strobe while busy
            @(negedge clk); line_start = 1'b0;
            repeat (1100) @(negedge clk);
        end else begin
            repeat (1700) @(negedge clk);
        end
        checks++;
        if (win_cycles != expect_win) begin
            fails++;
            $display("FAIL %s window cycles actual=%0d expected=%0d", tag, win_cycles, expect_win);
        end
    endtask

    always @(posedge clk) begin
        if (!done && cyc >= WDOG) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog cyc=%0d actual=hung expected=finished", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        checks++;
        if (vid_win !== 1'b0 || vid_lvl !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%b%b expected=00", vid_win, vid_lvl);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10/R7: written but not loaded -> zero payload still sent (R1, R6)
        tag = "R7";
        wr(1'b0, 8'hED);
        wr(1'b1, 8'hA5);
        line(20, 1'b1, WIN, 1'b0);

        // R3/R4/R5: loaded payload on line 20
        tag = "R5";
        vs_pulse();
        line(20, 1'b1, WIN, 1'b0);

        // R6: all ones on line 283
        tag = "R6";
        wr(1'b0, 8'hFF);
        wr(1'b1, 8'hFF);
        vs_pulse();
        line(283, 1'b1, WIN, 1'b0);

        // R2: wrong line and disabled line stay silent
        tag = "R2";
        line(21, 1'b1, 0, 1'b0);
        line(20, 1'b0, 0, 1'b0);
        line(282, 1'b1, 0, 1'b0);

        // R7: write on same edge as vsync rise loads old shadow
        tag = "R7";
        wr(1'b0, 8'h12);
        @(negedge clk); vsync = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h3C;
        @(negedge clk); wr_en = 1'b0;
        repeat (2) @(negedge clk); vsync = 1'b0;
        line(283, 1'b1, WIN, 1'b0);

        // R9: retrigger while sending, mixed payload (R4 timing)
        tag = "R9";
        vs_pulse();
        line(20, 1'b1, WIN, 1'b1);
        tag = "R4";
        line(283, 1'b1, WIN, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule